// File: doc/BRIEF.md
# SPI Master Select Timing Sequencer

This block is an SPI master for a single slave. It takes 8-bit words on a valid/ready handshake and shifts each word out on MOSI in mode 0, most significant bit first. It captures MISO at the same time and returns each received word with a one-cycle strobe. Its main job is the placement of the active-low select line relative to the serial clock. The gap between select assertion and the first SCK edge can be lengthened by one SCK period. So can the gap between the last SCK edge and select release. A programmable number of idle SCK periods (0 to 255) follows every word.

Two small registers hold the settings, and software can read and write both. Every word takes a private copy of the settings at the moment it is accepted. A write made while a word is in flight therefore applies from the next word on. With an idle count of zero and a follow-on word already offered, words run back to back and select stays asserted between them.

Top module: `spi_xfer_seq`

## Requirements
- R1: Register 0 (cfg_addr=0) holds lag-extend at bit 9, lead-extend at bit 8 and the idle count at bits 7:0, and resets to 0x0301. Register 1 (cfg_addr=1) holds the divider D in bits 3:0 and resets to 0. Unimplemented bits read as 0. A read returns the last written value at once.
- R2: SCK is low whenever select is high. Each SCK half period lasts D+1 clock cycles, and each word makes exactly 8 rising edges.
- R3: From the select falling edge to the first SCK rise takes (D+1) cycles, or 3*(D+1) cycles when lag-extend is 1.
- R4: From the last SCK fall to the select rising edge takes (D+1) cycles, or 3*(D+1) cycles when lead-extend is 1.
- R5: MOSI carries the word MSB first. The first bit is present from the select fall, and MOSI changes only on SCK falling edges, so the byte seen at the 8 rising edges equals the byte sent.
- R6: MISO is captured on SCK rising edges. rx_valid pulses for one cycle, beginning at the last SCK fall of the word, and rx_data then holds the 8 captured bits, first bit in the MSB.
- R7: After select rises, busy stays high for idle_count*2*(D+1) cycles and then falls. With an idle count of 0, busy falls together with select.
- R8: With an idle count of 0 and a new word offered at the chaining point, select stays low and the next word's first SCK rise follows the previous word's last fall by D+1 cycles. Three chained words give 24 rising edges inside one select pulse.
- R9: Register writes made during a word do not alter that word's timing. They apply to the next accepted word.
- R10: busy rises on the cycle a word is accepted and covers the whole time select is low. tx_ready is high while idle and low during the select lag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select (0 timing, 1 divider) |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for cfg_addr |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word can be taken this cycle |
| tx_data | input | 8 | Transmit word |
| rx_valid | output | 1 | One-cycle strobe: received word ready |
| rx_data | output | 8 | Received word |
| busy | output | 1 | Word in progress, including its idle gap |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sel_n | output | 1 | Active-low slave select |

## Verification
The assertions assume that tx_valid, once raised, stays high until a handshake completes. They also assume that reset is released synchronously to clk. The bench raises valid only at falling clock edges and holds it until it sees tx_ready. It moves to the next word only after busy falls, except in the chained case, where a new word is offered straight after the previous acceptance. The slave model drives MISO only after SCK or select has fallen, so the value is stable at each rising-edge capture.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  localparam int unsigned REG_W  = 16;
  localparam int unsigned DIV_W  = 4;
  localparam int unsigned STOP_W = 8;
  localparam int unsigned TMR_W  = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAG,
    ST_SHIFT,
    ST_LEAD,
    ST_STOP
  } seq_state_t;

  typedef struct packed {
    logic              lag_ext;
    logic              lead_ext;
    logic [STOP_W-1:0] stop;
    logic [DIV_W-1:0]  div;
  } timing_cfg_t;

  // One SCK half period in system clock cycles.
  function automatic logic [TMR_W-1:0] half_len(input logic [DIV_W-1:0] d);
    return TMR_W'(d) + TMR_W'(1);
  endfunction

  // Select fall to first SCK rise.
  function automatic logic [TMR_W-1:0] lag_len(input logic [DIV_W-1:0] d,
                                               input logic ext);
    logic [TMR_W-1:0] h;
    h = half_len(d);
    return ext ? (h + (h << 1)) : h;
  endfunction

  // Extra time inserted after the trailing low half when lead is extended.
  function automatic logic [TMR_W-1:0] lead_extra_len(input logic [DIV_W-1:0] d);
    return half_len(d) << 1;
  endfunction

  // Idle time after select release.
  function automatic logic [TMR_W-1:0] gap_len(input logic [DIV_W-1:0] d,
                                               input logic [STOP_W-1:0] s);
    return TMR_W'(s) * (half_len(d) << 1);
  endfunction

endpackage

// File: rtl/spi_seq_regs.sv
module spi_seq_regs
  import spi_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  input  logic             snap,
  output logic [REG_W-1:0] rdata,
  output timing_cfg_t      act_cfg,
  output timing_cfg_t      nxt_cfg
);

  localparam logic [STOP_W-1:0] STOP_RST = STOP_W'(1);
  localparam int unsigned LAG_BIT  = STOP_W + 1;
  localparam int unsigned LEAD_BIT = STOP_W;

  timing_cfg_t stg_cfg;
  logic        unused_wbits;

  assign unused_wbits = ^wdata[REG_W-1:LAG_BIT+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_cfg.lag_ext  <= 1'b1;
      stg_cfg.lead_ext <= 1'b1;
      stg_cfg.stop     <= STOP_RST;
      stg_cfg.div      <= '0;
    end else if (wr_en) begin
      if (!addr) begin
        stg_cfg.lag_ext  <= wdata[LAG_BIT];
        stg_cfg.lead_ext <= wdata[LEAD_BIT];
        stg_cfg.stop     <= wdata[STOP_W-1:0];
      end else begin
        stg_cfg.div <= wdata[DIV_W-1:0];
      end
    end
  end

  // Per-word copy, taken when a word is accepted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_cfg.lag_ext  <= 1'b1;
      act_cfg.lead_ext <= 1'b1;
      act_cfg.stop     <= STOP_RST;
      act_cfg.div      <= '0;
    end else if (snap) begin
      act_cfg <= stg_cfg;
    end
  end

  assign nxt_cfg = snap ? stg_cfg : act_cfg;

  always_comb begin
    rdata = '0;
    if (!addr) begin
      rdata[LAG_BIT]      = stg_cfg.lag_ext;
      rdata[LEAD_BIT]     = stg_cfg.lead_ext;
      rdata[STOP_W-1:0]   = stg_cfg.stop;
    end else begin
      rdata[DIV_W-1:0]    = stg_cfg.div;
    end
  end

  // R9: the working copy only moves on a snapshot.
  a_r9_copy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(act_cfg));

endmodule

// File: rtl/spi_seq_shift.sv
module spi_seq_shift #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_data,
  input  logic              shift,
  input  logic              sample,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_data
);

  logic [WORD_W-1:0] tx_sr;
  logic [WORD_W-1:0] rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
    end else if (load) begin
      tx_sr <= load_data;
    end else if (shift) begin
      tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr <= '0;
    end else if (sample) begin
      rx_sr <= {rx_sr[WORD_W-2:0], miso};
    end
  end

  assign mosi    = tx_sr[WORD_W-1];
  assign rx_data = rx_sr;

  // R5: a new word and a shift never collide.
  a_r5_load_or_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));

endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_valid,
  input  timing_cfg_t act_cfg,
  input  timing_cfg_t nxt_cfg,
  output logic        tx_ready,
  output logic        accept,
  output logic        sel_n,
  output logic        sck,
  output logic        busy,
  output logic        rx_valid,
  output logic        load_tx,
  output logic        shift_tx,
  output logic        sample_rx
);

  localparam int unsigned HALVES = 2 * WORD_W;
  localparam int unsigned HIDX_W = $clog2(HALVES);
  localparam logic [HIDX_W-1:0] LAST_H = HIDX_W'(HALVES - 1);
  localparam logic [HIDX_W-1:0] PEN_H  = HIDX_W'(HALVES - 2);

  seq_state_t        state;
  logic [TMR_W-1:0]  tcnt;
  logic [HIDX_W-1:0] hidx;
  logic              chain_q;

  // Named internal events.
  logic tick, in_shift, last_half, pen_half;
  logic chain_pt, enter_rise, enter_fall, word_end, release_sel, start_idle;

  assign tick       = (state != ST_IDLE) && (tcnt == '0);
  assign in_shift   = (state == ST_SHIFT);
  assign last_half  = (hidx == LAST_H);
  assign pen_half   = (hidx == PEN_H);
  assign chain_pt   = in_shift && tick && pen_half && (act_cfg.stop == '0);
  assign tx_ready   = (state == ST_IDLE) || chain_pt;
  assign accept     = tx_valid && tx_ready;
  assign start_idle = accept && (state == ST_IDLE);
  assign enter_rise = ((state == ST_LAG) && tick) ||
                      (in_shift && tick && ((hidx[0] && !last_half) ||
                                            (last_half && chain_q)));
  assign enter_fall = in_shift && tick && !hidx[0];
  assign word_end   = enter_fall && pen_half;
  assign release_sel = (in_shift && tick && last_half && !chain_q && !act_cfg.lead_ext) ||
                       ((state == ST_LEAD) && tick);

  assign busy      = (state != ST_IDLE);
  assign load_tx   = accept;
  assign shift_tx  = enter_fall && !pen_half;
  assign sample_rx = enter_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck      <= 1'b0;
      sel_n    <= 1'b1;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= word_end;
      if (enter_rise)      sck <= 1'b1;
      else if (enter_fall) sck <= 1'b0;
      if (start_idle)       sel_n <= 1'b0;
      else if (release_sel) sel_n <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tcnt    <= '0;
      hidx    <= '0;
      chain_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_idle) begin
            state <= ST_LAG;
            tcnt  <= lag_len(nxt_cfg.div, nxt_cfg.lag_ext) - TMR_W'(1);
          end
        end
        ST_LAG: begin
          if (tick) begin
            state <= ST_SHIFT;
            hidx  <= '0;
            tcnt  <= half_len(act_cfg.div) - TMR_W'(1);
          end else begin
            tcnt <= tcnt - TMR_W'(1);
          end
        end
        ST_SHIFT: begin
          if (!tick) begin
            tcnt <= tcnt - TMR_W'(1);
          end else if (!last_half) begin
            hidx <= hidx + HIDX_W'(1);
            tcnt <= half_len(act_cfg.div) - TMR_W'(1);
            if (chain_pt && tx_valid) chain_q <= 1'b1;
          end else if (chain_q) begin
            chain_q <= 1'b0;
            hidx    <= '0;
            tcnt    <= half_len(act_cfg.div) - TMR_W'(1);
          end else if (act_cfg.lead_ext) begin
            state <= ST_LEAD;
            tcnt  <= lead_extra_len(act_cfg.div) - TMR_W'(1);
          end else if (act_cfg.stop != '0) begin
            state <= ST_STOP;
            tcnt  <= gap_len(act_cfg.div, act_cfg.stop) - TMR_W'(1);
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_LEAD: begin
          if (!tick) begin
            tcnt <= tcnt - TMR_W'(1);
          end else if (act_cfg.stop != '0) begin
            state <= ST_STOP;
            tcnt  <= gap_len(act_cfg.div, act_cfg.stop) - TMR_W'(1);
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_STOP: begin
          if (tick) state <= ST_IDLE;
          else      tcnt  <= tcnt - TMR_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: serial clock only runs inside a select window.
  a_r2_sck_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !sel_n);

  // R2: every SCK transition follows a timer expiry.
  a_r2_edges_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sck) || $fell(sck)) |-> $past(tick));

  // R10: busy covers the whole select window.
  a_r10_busy_covers_select: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n |-> busy);

  // R6: received-word strobe lasts a single cycle.
  a_r6_rx_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R10: select asserts only after a handshake.
  a_r10_select_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_n) |-> $past(accept));

endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
  import spi_seq_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_addr,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              sel_n
);

  timing_cfg_t act_cfg;
  timing_cfg_t nxt_cfg;
  logic        accept;
  logic        load_tx;
  logic        shift_tx;
  logic        sample_rx;

  spi_seq_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .snap    (accept),
    .rdata   (cfg_rdata),
    .act_cfg (act_cfg),
    .nxt_cfg (nxt_cfg)
  );

  spi_seq_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_valid  (tx_valid),
    .act_cfg   (act_cfg),
    .nxt_cfg   (nxt_cfg),
    .tx_ready  (tx_ready),
    .accept    (accept),
    .sel_n     (sel_n),
    .sck       (sck),
    .busy      (busy),
    .rx_valid  (rx_valid),
    .load_tx   (load_tx),
    .shift_tx  (shift_tx),
    .sample_rx (sample_rx)
  );

  spi_seq_shift #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_tx),
    .load_data (tx_data),
    .shift     (shift_tx),
    .sample    (sample_rx),
    .miso      (miso),
    .mosi      (mosi),
    .rx_data   (rx_data)
  );

  // R5: MOSI holds steady while SCK is high.
  a_r5_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

endmodule

// File: tb/spi_xfer_seq_test.sv
module spi_xfer_seq_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [7:0]  tx_data = '0;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        busy, sck, mosi, sel_n;
  logic        miso = 1'b0;

  spi_xfer_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_data(rx_data), .busy(busy), .sck(sck), .mosi(mosi), .miso(miso),
    .sel_n(sel_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at cycle %0d",
               req, act, act, exp, exp, cyc);
    end
  endtask

  // Bench view of the staged and per-word settings.
  int s_lag = 1, s_lead = 1, s_stop = 1, s_div = 0;
  int m_lag = 1, m_lead = 1, m_stop = 1, m_div = 0;
  int w_lag, w_lead, w_stop, w_div;
  int exp_rises = 8;

  function automatic int f_half(input int d); return d + 1; endfunction
  function automatic int f_lag(input int d, input int e); return (d + 1) * (e ? 3 : 1); endfunction
  function automatic int f_lead(input int d, input int e); return (d + 1) * (e ? 3 : 1); endfunction
  function automatic int f_gap(input int d, input int s); return s * 2 * (d + 1); endfunction

  logic [7:0] txq [0:255];
  logic [7:0] slvq [0:255];
  int nq = 0, tidx = 0, ridx = 0, sidx = 0;

  task automatic wr(input bit a, input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    if (!a) begin s_lag = d[9]; s_lead = d[8]; s_stop = d[7:0]; end
    else s_div = d[3:0];
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input bit a, output logic [15:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic set_cfg(input int lag, input int lead, input int stop, input int div);
    wr(1'b0, 16'((lag << 9) | (lead << 8) | (stop & 255)));
    wr(1'b1, 16'(div & 15));
  endtask

  task automatic send(input logic [7:0] t, input logic [7:0] s);
    txq[nq] = t; slvq[nq] = s; nq++;
    @(negedge clk);
    tx_valid = 1'b1; tx_data = t;
    #1;
    while (!tx_ready) begin
      @(negedge clk);
      #1;
    end
    m_lag = s_lag; m_lead = s_lead; m_stop = s_stop; m_div = s_div;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor and slave model, away from the active edge.
  logic p_sel = 1'b1, p_sck = 1'b0, p_busy = 1'b0;
  int t_sf, t_rise, t_fall, t_sr, nrise, sbit;
  logic [7:0] mbyte, sbyte;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_sel && !sel_n) begin
        t_sf = cyc; nrise = 0;
        w_lag = m_lag; w_lead = m_lead; w_stop = m_stop; w_div = m_div;
        chk(busy == 1'b1, "R10 busy at select fall", busy, 1);
        chk(tx_ready == 1'b0, "R10 ready low in lag", tx_ready, 0);
        sbit = 0; sbyte = slvq[sidx]; miso = sbyte[7];
      end
      if (!p_sck && sck) begin
        if (nrise == 0) chk(cyc - t_sf == f_lag(w_div, w_lag), "R3 lag", cyc - t_sf, f_lag(w_div, w_lag));
        else chk(cyc - t_fall == f_half(w_div), "R2/R8 low half", cyc - t_fall, f_half(w_div));
        mbyte = {mbyte[6:0], mosi};
        nrise++;
        t_rise = cyc;
        if (nrise % 8 == 0) begin
          chk(mbyte == txq[tidx], "R5 mosi byte", mbyte, txq[tidx]);
          tidx++;
        end
      end
      if (p_sck && !sck) begin
        chk(cyc - t_rise == f_half(w_div), "R2 high half", cyc - t_rise, f_half(w_div));
        t_fall = cyc;
        sbit++;
        if (sbit == 8) begin sbit = 0; sidx++; sbyte = slvq[sidx]; end
        miso = sbyte[7 - sbit];
      end
      if (rx_valid) begin
        chk(rx_data == slvq[ridx], "R6 rx byte", rx_data, slvq[ridx]);
        chk(cyc == t_fall, "R6 rx at last fall", cyc, t_fall);
        ridx++;
      end
      if (!p_sel && sel_n) begin
        chk(cyc - t_fall == f_lead(w_div, w_lead), "R4 lead", cyc - t_fall, f_lead(w_div, w_lead));
        chk(nrise == exp_rises, "R8 rises per select", nrise, exp_rises);
        t_sr = cyc;
      end
      if (p_busy && !busy) begin
        chk(cyc - t_sr == f_gap(w_div, w_stop), "R7 idle gap", cyc - t_sr, f_gap(w_div, w_stop));
      end
      if (sel_n && sck) chk(1'b0, "R2 sck while deselected", sck, 0);
      p_sel = sel_n; p_sck = sck; p_busy = busy;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] r;
    int dummy;
    dummy = $urandom(32'd20250);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state.
    chk(sel_n == 1'b1, "R10 reset sel_n", sel_n, 1);
    chk(sck == 1'b0, "R2 reset sck", sck, 0);
    chk(busy == 1'b0, "R10 reset busy", busy, 0);
    chk(tx_ready == 1'b1, "R10 reset ready", tx_ready, 1);
    rd(1'b0, r); chk(r == 16'h0301, "R1 reset reg0", r, 16'h0301);
    rd(1'b1, r); chk(r == 16'h0000, "R1 reset reg1", r, 0);

    // Register masking and readback.
    wr(1'b0, 16'hFFFF); rd(1'b0, r); chk(r == 16'h03FF, "R1 reg0 mask", r, 16'h03FF);
    wr(1'b1, 16'hFFFF); rd(1'b1, r); chk(r == 16'h000F, "R1 reg1 mask", r, 16'h000F);
    wr(1'b0, 16'h0301); wr(1'b1, 16'h0000);

    // Default settings.
    send(8'hA5, 8'h3C); wait_idle();
    send(8'h01, 8'h80); wait_idle();

    // No extensions, divider 2, zero gap.
    set_cfg(0, 0, 0, 2);
    send(8'h7E, 8'hC3); wait_idle();
    send(8'h80, 8'h01); wait_idle();

    // Long idle gap.
    set_cfg(1, 0, 255, 0);
    send(8'hFF, 8'h00); wait_idle();

    // Chained words.
    set_cfg(1, 1, 0, 1);
    exp_rises = 24;
    send(8'h12, 8'hED);
    send(8'h34, 8'hCB);
    send(8'h56, 8'hA9);
    wait_idle();
    exp_rises = 8;

    // R9: write during a word applies to the next word only.
    set_cfg(1, 1, 2, 1);
    send(8'h5A, 8'h96);
    @(posedge sck);
    wr(1'b0, 16'h0005);
    wr(1'b1, 16'h0003);
    rd(1'b0, r); chk(r == 16'h0005, "R1 R9 readback of staged", r, 16'h0005);
    wait_idle();
    send(8'hC7, 8'h2D); wait_idle();

    // Random words.
    for (int i = 0; i < 40; i++) begin
      if (i % 4 == 0) begin
        int st;
        st = ($urandom % 3 == 0) ? 0 : int'($urandom % 5);
        set_cfg(int'($urandom % 2), int'($urandom % 2), st, int'($urandom % 4));
      end
      send(8'($urandom), 8'($urandom));
      wait_idle();
    end

    chk(tidx == nq, "R5 all words sent", tidx, nq);
    chk(ridx == nq, "R6 all words received", ridx, nq);
    finish_run();
  end

endmodule